// File: doc/BRIEF.md
# Manchester Decoder with Digital Clock Recovery

The block takes an oversampled Manchester line (one sample per clock, `SAMPLES_PER_BIT` samples per bit cell) and recovers a bit strobe and NRZ data once an external carrier-detect enable is raised. Its bit oscillator is a numerically controlled phase accumulator, kept in units of 1/2^`FRAC_BITS` of a sample. While the receiver is disabled or searching, the accumulator free-runs at the nominal rate of one sample per clock, so it stays locked to local transmit timing.

Acquisition is keyed to the preamble 1,0,1,0. A falling mid-cell transition encodes a 0 (line high then low) and a rising one encodes a 1. After the enable rises, the first rising transition marks the centre of cell 1. The next falling transition, at the centre of cell 2, stops the accumulator. The accumulator stays frozen until a second falling transition arrives, which is the centre of cell 4. That transition restarts it aligned to the cell centre, so acquisition takes four bit times. The quarter-bit point of cell 4 is swallowed. Strobes and data start in cell 5, which carries a 1. After that, every transition close to a cell centre nudges the phase by roughly a tenth of the measured error. This filters jitter by about ten to one.

The MAC framing, the line receiver and any analog oscillator are outside the block.

Top module: `manchester_clk_recovery`

## Requirements
- R1: After reset, `rxStrobe` is 0, `rxData` is 1 and `rxValid` is 0.
- R2: While `rxEnable` is low, any line activity leaves `rxStrobe` at 0, `rxData` at 1 and `rxValid` at 0.
- R3: After enable, a rising transition arms the search. The following falling transition freezes the phase. A falling transition that comes fewer than `SAMPLES_PER_BIT` samples after the freeze is ignored. A later falling transition restarts the phase at cell centre, with the next clock one sample past centre.
- R4: If no qualifying second falling transition arrives within 3×`SAMPLES_PER_BIT` samples of the freeze, the search returns to waiting for a rising transition. A later valid preamble still acquires.
- R5: The quarter-bit crossing of cell 4 produces no strobe. The first strobe belongs to cell 5, which is sample index 75 of the frame at 16 samples per bit. `rxValid` rises together with that first strobe and then stays high while enabled.
- R6: Each strobe presents the line sample taken in the last clock before the recovered phase reaches a quarter bit past centre (the second-half level, 0 for high-then-low). `rxData` changes only with a strobe.
- R7: Exactly one single-cycle strobe is issued per bit cell. With a jitter-free line, consecutive strobes are `SAMPLES_PER_BIT` clocks apart.
- R8: When locked, a transition whose phase error e (signed, in 1/16-sample units, wrapped to ±half cell) lies strictly inside ±quarter bit changes that clock's phase advance by −floor(13·e/128). Transitions outside that window, including cell-boundary transitions, leave the phase unchanged. With mid-cell jitter of up to ±2 samples, or a steady 3-sample offset, the data is decoded without error.
- R9: One clock after `rxEnable` falls, the outputs are back at their idle values (strobe 0, data 1, valid 0), and the phase free-runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one line sample per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| lineIn | input | 1 | Sampled Manchester line |
| rxEnable | input | 1 | Carrier-detect enable from the line receiver |
| rxStrobe | output | 1 | One-cycle recovered bit clock strobe |
| rxData | output | 1 | Decoded NRZ data, high when idle |
| rxValid | output | 1 | High from the first decoded bit until the enable drops |

## Verification
The bound checker checks the following on every clock:
- the outputs go idle one cycle after the enable drops;
- strobes are isolated single-cycle pulses;
- the valid flag rises only with a strobe and falls only after a disable;
- data moves only with a strobe;
- a phase restart coincides with a falling line transition.

The exact placement of the first strobe in cell 5, the ten-percent phase pull under jitter and steady offset, noise rejection during the frozen interval and recovery after an acquisition timeout depend on the line history. Only the bench scenarios can show these, using its behavioural model compared every clock and its decoded-bit checks.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEEK,
    ST_HUNT,
    ST_HALT,
    ST_LOCK
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;   // free-run the phase by one sample
    logic restart;   // align phase to cell centre
    logic track;     // locked: advance with correction
    logic emit;      // quarter-bit crossings may produce strobes
    logic idleOut;   // force outputs to idle values
  } phaseCtrl_t;

  localparam int CORR_NUM   = 13;
  localparam int CORR_SHIFT = 7;

endpackage

// File: rtl/mcr_datapath.sv
module mcr_datapath
  import mcr_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 16,
  parameter int FRAC_BITS       = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lineIn,
  input  phaseCtrl_t ctl,
  output logic       riseEdge,
  output logic       fallEdge,
  output logic       quarterCross,
  output logic       rxStrobe,
  output logic       rxData,
  output logic       rxValid
);

  localparam int PH_W    = $clog2(SAMPLES_PER_BIT) + FRAC_BITS;
  localparam int EW      = PH_W + 5;
  localparam int STEP    = 1 << FRAC_BITS;
  localparam int QUARTER = (1 << PH_W) / 4;

  logic            lineD;
  logic [PH_W-1:0] phase;
  logic            anyEdge;
  logic            inWindow;
  logic signed [EW-1:0] errX;
  logic signed [EW-1:0] prodX;
  logic signed [EW-1:0] corrX;
  logic signed [EW-1:0] incX;
  logic [EW-1:0]   nextU;

  always_comb begin
    anyEdge  = lineD ^ lineIn;
    riseEdge = ~lineD & lineIn;
    fallEdge = lineD & ~lineIn;
    // phase read as two's complement: error relative to cell centre
    errX     = {{(EW-PH_W){phase[PH_W-1]}}, phase};
    inWindow = (errX > -$signed(EW'(QUARTER))) && (errX < $signed(EW'(QUARTER)));
    prodX    = errX * $signed(EW'(CORR_NUM));
    corrX    = prodX >>> CORR_SHIFT;
    incX     = $signed(EW'(STEP)) - ((anyEdge && inWindow) ? corrX : '0);
    nextU    = EW'(phase) + $unsigned(incX);
    quarterCross = ctl.track && (phase < PH_W'(QUARTER)) && (nextU >= EW'(QUARTER));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineD <= 1'b0;
      phase <= '0;
    end else begin
      lineD <= lineIn;
      if (ctl.restart)
        phase <= PH_W'(STEP);
      else if (ctl.track)
        phase <= nextU[PH_W-1:0];
      else if (ctl.advance)
        phase <= phase + PH_W'(STEP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxStrobe <= 1'b0;
      rxData   <= 1'b1;
      rxValid  <= 1'b0;
    end else if (ctl.idleOut) begin
      rxStrobe <= 1'b0;
      rxData   <= 1'b1;
      rxValid  <= 1'b0;
    end else begin
      rxStrobe <= ctl.emit && quarterCross;
      if (ctl.emit && quarterCross) begin
        rxData  <= lineIn;
        rxValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mcr_control.sv
module mcr_control
  import mcr_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxEnable,
  input  logic       riseEdge,
  input  logic       fallEdge,
  input  logic       quarterCross,
  output phaseCtrl_t ctl
);

  localparam int LIMIT = 3 * SAMPLES_PER_BIT;
  localparam int CW    = $clog2(LIMIT + 1);

  rxState_e state;
  logic [CW-1:0] haltCnt;
  logic armed;

  always_comb begin
    ctl = '0;
    if (!rxEnable) begin
      ctl.advance = 1'b1;
      ctl.idleOut = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE, ST_SEEK: begin
          ctl.advance = 1'b1;
          ctl.idleOut = 1'b1;
        end
        ST_HUNT: begin
          ctl.advance = ~fallEdge;
          ctl.idleOut = 1'b1;
        end
        ST_HALT: begin
          ctl.idleOut = 1'b1;
          ctl.restart = fallEdge && (haltCnt >= CW'(SAMPLES_PER_BIT));
        end
        ST_LOCK: begin
          ctl.track = 1'b1;
          ctl.emit  = armed;
        end
        default: ctl.idleOut = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      haltCnt <= '0;
      armed   <= 1'b0;
    end else if (!rxEnable) begin
      state   <= ST_IDLE;
      haltCnt <= '0;
      armed   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: state <= ST_SEEK;
        ST_SEEK: if (riseEdge) state <= ST_HUNT;
        ST_HUNT: if (fallEdge) begin
          state   <= ST_HALT;
          haltCnt <= '0;
        end
        ST_HALT: begin
          if (ctl.restart) begin
            state <= ST_LOCK;
            armed <= 1'b0;
          end else if (haltCnt == CW'(LIMIT)) begin
            state <= ST_SEEK;
          end else begin
            haltCnt <= haltCnt + 1'b1;
          end
        end
        ST_LOCK: if (quarterCross) armed <= 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/manchester_clk_recovery.sv
module manchester_clk_recovery
  import mcr_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 16,
  parameter int FRAC_BITS       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lineIn,
  input  logic rxEnable,
  output logic rxStrobe,
  output logic rxData,
  output logic rxValid
);

  phaseCtrl_t phaseCtl;
  logic riseEdge;
  logic fallEdge;
  logic quarterCross;

  mcr_control #(
    .SAMPLES_PER_BIT(SAMPLES_PER_BIT)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .rxEnable     (rxEnable),
    .riseEdge     (riseEdge),
    .fallEdge     (fallEdge),
    .quarterCross (quarterCross),
    .ctl          (phaseCtl)
  );

  mcr_datapath #(
    .SAMPLES_PER_BIT(SAMPLES_PER_BIT),
    .FRAC_BITS      (FRAC_BITS)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .lineIn       (lineIn),
    .ctl          (phaseCtl),
    .riseEdge     (riseEdge),
    .fallEdge     (fallEdge),
    .quarterCross (quarterCross),
    .rxStrobe     (rxStrobe),
    .rxData       (rxData),
    .rxValid      (rxValid)
  );

endmodule

// File: rtl/mcr_checker.sv
module mcr_checker (
  input logic clk,
  input logic rst_n,
  input logic rxEnable,
  input logic rxStrobe,
  input logic rxData,
  input logic rxValid,
  input logic restart,
  input logic fallEdge
);

  // R2
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEnable |=> (!rxStrobe && rxData && !rxValid));

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxValid) |-> !$past(rxEnable));

  // R7
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxStrobe |=> !rxStrobe);

  // R5
  strobe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxStrobe |-> rxValid);

  // R5
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxValid) |-> rxStrobe);

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxValid && $past(rxValid) && !$stable(rxData)) |-> rxStrobe);

  // R3
  restart_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> fallEdge);

endmodule

bind manchester_clk_recovery mcr_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rxEnable (rxEnable),
  .rxStrobe (rxStrobe),
  .rxData   (rxData),
  .rxValid  (rxValid),
  .restart  (phaseCtl.restart),
  .fallEdge (fallEdge)
);

// File: tb/manchester_clk_recovery_tb.sv
module manchester_clk_recovery_tb;

  localparam int SPB   = 16;
  localparam int PMOD  = 256;
  localparam int STEP  = 16;
  localparam int QTR   = 64;
  localparam int LIMIT = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lineIn = 1'b0;
  logic rxEnable = 1'b0;
  logic rxStrobe, rxData, rxValid;

  manchester_clk_recovery u_dut (
    .clk(clk), .rst_n(rst_n), .lineIn(lineIn), .rxEnable(rxEnable),
    .rxStrobe(rxStrobe), .rxData(rxData), .rxValid(rxValid)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural reference state (0 idle,1 seek,2 hunt,3 halt,4 lock)
  int mState = 0, mPhase = 0, mCnt = 0;
  bit mArmed = 0, mLineD = 0;
  bit eStrobe = 0, eData = 1, eValid = 0;

  int sampleIdx = 0;
  bit gotBits[$];
  int strobeAt[$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int floorDiv128(input int v);
    if (v >= 0) return v / 128;
    return -((-v + 127) / 128);
  endfunction

  task automatic modelStep(input bit ln, input bit en);
    bit fall, rise, anyE, qc;
    int e, corr, nxt;
    fall = mLineD && !ln;
    rise = !mLineD && ln;
    anyE = mLineD != ln;
    if (!en) begin
      mPhase = (mPhase + STEP) % PMOD;
      mState = 0; mCnt = 0; mArmed = 0;
      eStrobe = 0; eData = 1; eValid = 0;
    end else begin
      case (mState)
        0: begin
          mPhase = (mPhase + STEP) % PMOD; mState = 1;
          eStrobe = 0; eData = 1; eValid = 0;
        end
        1: begin
          mPhase = (mPhase + STEP) % PMOD;
          if (rise) mState = 2;
          eStrobe = 0; eData = 1; eValid = 0;
        end
        2: begin
          if (fall) begin mState = 3; mCnt = 0; end
          else mPhase = (mPhase + STEP) % PMOD;
          eStrobe = 0; eData = 1; eValid = 0;
        end
        3: begin
          eStrobe = 0; eData = 1; eValid = 0;
          if (fall && mCnt >= SPB) begin
            mState = 4; mPhase = STEP; mArmed = 0;
          end else if (mCnt == LIMIT) mState = 1;
          else mCnt++;
        end
        default: begin
          e = (mPhase >= PMOD/2) ? mPhase - PMOD : mPhase;
          corr = 0;
          if (anyE && e > -QTR && e < QTR) corr = floorDiv128(e * 13);
          nxt = mPhase + STEP - corr;
          qc = (mPhase < QTR) && (nxt >= QTR);
          if (qc && mArmed) begin eStrobe = 1; eData = ln; eValid = 1; end
          else eStrobe = 0;
          if (qc) mArmed = 1;
          mPhase = nxt % PMOD;
        end
      endcase
    end
    mLineD = ln;
  endtask

  task automatic tick(input bit ln, input bit en);
    string tag;
    tag = !en ? "R9" : (mState == 4 ? "R8" : "R3");
    lineIn = ln;
    rxEnable = en;
    modelStep(ln, en);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (rxStrobe !== eStrobe || rxData !== eData || rxValid !== eValid) begin
      errors++;
      $display("FAIL %s per-cycle model actual=%b%b%b expected=%b%b%b (strobe,data,valid) at %0d",
               tag, rxStrobe, rxData, rxValid, eStrobe, eData, eValid, sampleIdx);
    end
    if (rxStrobe === 1'b1) begin
      gotBits.push_back(rxData);
      strobeAt.push_back(sampleIdx);
    end
    sampleIdx++;
  endtask

  function automatic int shiftFor(input int mode, input int c);
    if (mode == 1) return (c % 5) - 2;
    if (mode == 2) return 3;
    return 0;
  endfunction

  // sends preamble 1,0,1,0, the cell-5 one and the payload, then disables
  task automatic runFrame(input bit payload[$], input int mode, input bit glitch,
                          input int expFirst, input bit checkGaps);
    bit cells[$];
    bit v;
    int s;
    cells = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    foreach (payload[k]) cells.push_back(payload[k]);
    gotBits.delete();
    strobeAt.delete();
    sampleIdx = 0;
    foreach (cells[c]) begin
      s = (c >= 5) ? shiftFor(mode, c) : 0;
      for (int i = 0; i < SPB; i++) begin
        v = (i < 8 + s) ? !cells[c] : cells[c];
        if (glitch && c == 1 && i == 12) v = 1'b1;
        tick(v, 1'b1);
      end
    end
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1);
    chk("R7 strobe count", gotBits.size(), cells.size() - 4);
    for (int k = 0; k < gotBits.size() && k + 4 < cells.size(); k++)
      chk("R6 decoded bit", gotBits[k], cells[k+4]);
    if (mode != 0) chk("R8 tracked frame decoded", gotBits.size(), cells.size() - 4);
    if (expFirst >= 0 && strobeAt.size() > 0) chk("R5 first strobe index", strobeAt[0], expFirst);
    if (checkGaps)
      for (int k = 1; k < strobeAt.size(); k++)
        chk("R7 strobe spacing", strobeAt[k] - strobeAt[k-1], SPB);
    chk("R5 valid held before disable", rxValid, 1);
    tick(1'b1, 1'b0);
    chk("R9 strobe after disable", rxStrobe, 0);
    chk("R9 data after disable", rxData, 1);
    chk("R9 valid after disable", rxValid, 0);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
  endtask

  task automatic enablePrelude();
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b1);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit pay[$];
    int bad;
    repeat (3) @(negedge clk);
    chk("R1 reset strobe", rxStrobe, 0);
    chk("R1 reset data", rxData, 1);
    chk("R1 reset valid", rxValid, 0);
    rst_n = 1'b1;

    // R2: line activity including a preamble shape while disabled
    bad = 0;
    for (int i = 0; i < 96; i++) begin
      tick(((i / 8) % 2) == 0, 1'b0);
      if (rxStrobe !== 1'b0 || rxData !== 1'b1 || rxValid !== 1'b0) bad++;
    end
    chk("R2 disabled outputs idle", bad, 0);

    // clean frame: exact timing of first strobe and spacing
    pay = '{1,0,0,1,1,0,1,0,0,0,1,1,1,0,1,1};
    enablePrelude();
    runFrame(pay, 0, 1'b0, 75, 1'b1);

    // noise fall during the frozen interval must be ignored
    enablePrelude();
    runFrame(pay, 0, 1'b1, 75, 1'b0);

    // alternating jitter of up to two samples
    pay = '{0,1,1,0,1,0,0,1,1,1,0,0,1,0,1,0,0,1,1,0,1,1,0,0};
    enablePrelude();
    runFrame(pay, 1, 1'b0, 75, 1'b0);

    // steady late offset of three samples, long payload
    pay.delete();
    for (int k = 0; k < 40; k++) pay.push_back(((k * 7) % 3) == 1);
    enablePrelude();
    runFrame(pay, 2, 1'b0, -1, 1'b0);

    // R4: a lone fall with no second zero times out, then acquisition recovers
    enablePrelude();
    for (int i = 0; i < 8; i++) tick(1'b0, 1'b1);
    for (int i = 0; i < 8; i++) tick(1'b1, 1'b1);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      tick(1'b0, 1'b1);
      if (rxValid !== 1'b0 || rxStrobe !== 1'b0) bad++;
    end
    chk("R4 no lock without second zero", bad, 0);
    pay = '{1,1,0,1,0,0,1,0};
    runFrame(pay, 0, 1'b0, 75, 1'b1);
    chk("R4 recovery frame bits", gotBits.size(), 9);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule